// File: doc/BRIEF.md
# Multifunction IO Pin Controller

This block looks after seven general-purpose digital pins. Each pin can be set up as an output that shows one of the chip's internal status signals, or as an input that drives one of the chip's internal control functions. Each pin has an 8-bit function register and a 2-bit mode field, both loaded through a register write port. New settings go into a staging copy first. They reach the live configuration only when the update strobe is pulsed.

On an output pin, the mode field chooses how the pin drives the pad. There are four choices: push-pull active high, push-pull active low, open-drain pulling high, and open-drain pulling low. On an input pin, the same 2-bit code places the pin in the AND group or the OR group of its control function, taking either the true or the inverted pad level.

Each control output is the AND of every term in its AND group with the OR of the terms in its OR group. A pin whose settings have just been written goes quiet until the next update strobe: it neither drives its pad nor feeds the combiner. Pad inputs pass through a two-stage synchronizer before they are combined.

Top module: `mfp_pins`

## Requirements
- R1: After reset every pin is an input mapped to no function. The reset values are mode 00 and function register 0x7F. Until the first update strobe, all `padOe` bits and all `ctrlOut` bits are 0.
- R2: An output pin in mode 00 drives `padOe`=1 and drives `padOut` equal to its monitored signal. In mode 01 it drives `padOe`=1 and `padOut` equal to the inverse of that signal.
- R3: An output pin in mode 10 gives `padOe` = monitored signal and `padOut`=1. In mode 11 it gives `padOe` = monitored signal and `padOut`=0. Either way the pad floats while the signal is low.
- R4: Bit 7 of a function register set to 1 makes the pin an output. Bits 6:0 then select `statusIn` bit n. A selection at or above the `statusIn` width reads as deasserted.
- R5: A write reaches a pin's function register through address 8+p. A write reaches its mode field through the mode bank at address p/4, bits [2*(p%4)+1 : 2*(p%4)]. From the cycle after such a write until the next update strobe, the pin drives `padOe`=0 and takes no part in any control function.
- R6: A `cfgUpdate` pulse copies the staged mode and function of every pin into the live configuration. It also ends every quiet period. The new settings act from the next cycle.
- R7: An input pin is one whose function register has bit 7 = 0 and bits 6:0 = f. Its mode then adds a term to control f, as follows:
  - 00 adds the true pad level to the AND group.
  - 01 adds the inverted pad level to the AND group.
  - 10 adds the true pad level to the OR group.
  - 11 adds the inverted pad level to the OR group.
- R8: An empty OR group counts as true, and so does an empty AND group. A control output with no active pin mapped to it is 0.
- R9: A pad level change made between two rising edges reaches `ctrlOut` after the second of the following rising edges, and not after the first.
- R10: Some writes are ignored and leave every pin's staged and live state unchanged. These are writes to function addresses of pins that do not exist (8+p with p ≥ 7) and writes to mode-bank addresses beyond the last bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Write address. 0..1 are mode banks; 8..14 are function registers |
| wrData | input | 8 | Write data |
| cfgUpdate | input | 1 | Update strobe; makes the staged configuration live |
| statusIn | input | 16 | Internal status signals that output pins can monitor |
| padIn | input | 7 | Pad input levels |
| padOut | output | 7 | Pad output levels |
| padOe | output | 7 | Pad output enables |
| ctrlOut | output | 8 | Combined control function outputs |

## Verification
The assertions rely on three assumptions:
- A register write and an update strobe never fall in the same cycle.
- `statusIn` changes only when the pad outputs are allowed to follow it.
- Pad inputs settle away from the clock edge.

The bench meets these assumptions in four ways:
- It drives every input at the falling edge.
- It issues writes and strobes from separate tasks, each one cycle long.
- It changes status and pad levels only between those tasks.
- It samples outputs at the falling edge after the register stages that lead to them.

// File: rtl/mfp_pkg.sv
`timescale 1ns/1ps
package mfp_pkg;
  localparam int CFG_ADDR_W = 4;
  localparam int IDX_W      = CFG_ADDR_W - 1;

  typedef enum logic [1:0] {
    MODE_PP_HIGH = 2'b00,
    MODE_PP_LOW  = 2'b01,
    MODE_OD_HIGH = 2'b10,
    MODE_OD_LOW  = 2'b11
  } padMode_e;

  // strobes from the write decoder to the datapath
  typedef struct packed {
    logic             modeWr;  // idx is a mode bank
    logic             funcWr;  // idx is a pin number
    logic             commit;
    logic [IDX_W-1:0] idx;
  } cfgStrobe_t;
endpackage

// File: rtl/mfp_ctrl.sv
`timescale 1ns/1ps
module mfp_ctrl
  import mfp_pkg::*;
#(
  parameter int NUM_PINS = 7
) (
  input  logic                  wrEn,
  input  logic [CFG_ADDR_W-1:0] wrAddr,
  input  logic                  cfgUpdate,
  output cfgStrobe_t            strb
);
  localparam int PINS_PER_BANK = 4;
  localparam int NUM_BANKS     = (NUM_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK;

  logic           isFuncSpace;
  logic [IDX_W:0] idxWide;

  assign isFuncSpace = wrAddr[CFG_ADDR_W-1];
  assign idxWide     = {1'b0, wrAddr[IDX_W-1:0]};

  always_comb begin
    strb        = '0;
    strb.idx    = wrAddr[IDX_W-1:0];
    strb.commit = cfgUpdate;
    strb.funcWr = wrEn && isFuncSpace && (idxWide < (IDX_W+1)'(NUM_PINS));
    strb.modeWr = wrEn && !isFuncSpace && (idxWide < (IDX_W+1)'(NUM_BANKS));
  end
endmodule

// File: rtl/mfp_datapath.sv
`timescale 1ns/1ps
module mfp_datapath
  import mfp_pkg::*;
#(
  parameter int NUM_PINS   = 7,
  parameter int NUM_STATUS = 16,
  parameter int NUM_CTRL   = 8,
  parameter int SEL_W      = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            strb,
  input  logic [SEL_W:0]        wrData,
  input  logic [NUM_STATUS-1:0] statusIn,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_CTRL-1:0]   ctrlOut
);
  localparam int FUNC_W        = SEL_W + 1;
  localparam int PINS_PER_BANK = 4;
  localparam int SEL_SPAN      = 2 ** SEL_W;
  localparam logic [FUNC_W-1:0] FUNC_RESET = {1'b0, {SEL_W{1'b1}}};

  padMode_e            stgMode [NUM_PINS];
  padMode_e            actMode [NUM_PINS];
  logic [FUNC_W-1:0]   stgFunc [NUM_PINS];
  logic [FUNC_W-1:0]   actFunc [NUM_PINS];
  logic [NUM_PINS-1:0] quiet, touchFunc, touchMode;
  logic [NUM_PINS-1:0] syncA, syncB;
  logic [SEL_SPAN-1:0] statusWide;

  assign statusWide = {{(SEL_SPAN-NUM_STATUS){1'b0}}, statusIn};

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      touchFunc[p] = strb.funcWr && (strb.idx == IDX_W'(p));
      touchMode[p] = strb.modeWr && (strb.idx == IDX_W'(p / PINS_PER_BANK));
    end
  end

  // staging, live copy and quiet flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        stgMode[p] <= MODE_PP_HIGH;
        actMode[p] <= MODE_PP_HIGH;
        stgFunc[p] <= FUNC_RESET;
        actFunc[p] <= FUNC_RESET;
      end
      quiet <= '0;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (touchFunc[p]) stgFunc[p] <= wrData;
        if (touchMode[p]) stgMode[p] <= padMode_e'(wrData[2*(p%PINS_PER_BANK) +: 2]);
        if (strb.commit) begin
          actMode[p] <= stgMode[p];
          actFunc[p] <= stgFunc[p];
        end
        if (touchFunc[p] || touchMode[p]) quiet[p] <= 1'b1;
        else if (strb.commit)             quiet[p] <= 1'b0;
      end
    end
  end

  // two-stage input synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // output drive
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      logic isMon, asserted;
      isMon    = actFunc[p][FUNC_W-1] && !quiet[p];
      asserted = isMon && statusWide[actFunc[p][SEL_W-1:0]];
      unique case (actMode[p])
        MODE_PP_HIGH: begin padOe[p] = isMon;    padOut[p] = asserted;          end
        MODE_PP_LOW:  begin padOe[p] = isMon;    padOut[p] = isMon && !asserted; end
        MODE_OD_HIGH: begin padOe[p] = asserted; padOut[p] = isMon;             end
        MODE_OD_LOW:  begin padOe[p] = asserted; padOut[p] = 1'b0;              end
        default:      begin padOe[p] = 1'b0;     padOut[p] = 1'b0;              end
      endcase
    end
  end

  // input combiner
  always_comb begin
    for (int f = 0; f < NUM_CTRL; f++) begin
      logic anyPin, andOk, orUsed, orHit;
      anyPin = 1'b0;
      andOk  = 1'b1;
      orUsed = 1'b0;
      orHit  = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (!actFunc[p][FUNC_W-1] && !quiet[p] &&
            actFunc[p][SEL_W-1:0] == SEL_W'(f)) begin
          anyPin = 1'b1;
          if (actMode[p][1]) begin
            orUsed = 1'b1;
            orHit  = orHit | (syncB[p] ^ actMode[p][0]);
          end else begin
            andOk  = andOk & (syncB[p] ^ actMode[p][0]);
          end
        end
      end
      ctrlOut[f] = anyPin && andOk && (!orUsed || orHit);
    end
  end
endmodule

// File: rtl/mfp_pins.sv
`timescale 1ns/1ps
module mfp_pins
  import mfp_pkg::*;
#(
  parameter int NUM_PINS   = 7,
  parameter int NUM_STATUS = 16,
  parameter int NUM_CTRL   = 8,
  parameter int SEL_W      = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [CFG_ADDR_W-1:0] wrAddr,
  input  logic [SEL_W:0]        wrData,
  input  logic                  cfgUpdate,
  input  logic [NUM_STATUS-1:0] statusIn,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_CTRL-1:0]   ctrlOut
);
  cfgStrobe_t strb;

  mfp_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .cfgUpdate(cfgUpdate), .strb(strb)
  );

  mfp_datapath #(
    .NUM_PINS(NUM_PINS), .NUM_STATUS(NUM_STATUS),
    .NUM_CTRL(NUM_CTRL), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .statusIn(statusIn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .ctrlOut(ctrlOut)
  );
endmodule

// File: rtl/mfp_pins_chk.sv
`timescale 1ns/1ps
module mfp_pins_chk
  import mfp_pkg::*;
#(
  parameter int NUM_PINS   = 7,
  parameter int NUM_STATUS = 16,
  parameter int NUM_CTRL   = 8,
  parameter int SEL_W      = 7
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [CFG_ADDR_W-1:0] wrAddr,
  input logic [SEL_W:0]        wrData,
  input logic                  cfgUpdate,
  input logic [NUM_STATUS-1:0] statusIn,
  input logic [NUM_PINS-1:0]   padIn,
  input logic [NUM_PINS-1:0]   padOut,
  input logic [NUM_PINS-1:0]   padOe,
  input logic [NUM_CTRL-1:0]   ctrlOut
);
  logic [1:0] warm;
  logic       seenCommit;
  logic       funcWrHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warm       <= '0;
      seenCommit <= 1'b0;
    end else begin
      if (warm != 2'd3) warm <= warm + 2'd1;
      if (cfgUpdate) seenCommit <= 1'b1;
    end
  end

  assign funcWrHit = wrEn && wrAddr[CFG_ADDR_W-1] &&
                     ({1'b0, wrAddr[CFG_ADDR_W-2:0]} < CFG_ADDR_W'(NUM_PINS));

  assert_idle_until_commit_R1: assert property (@(posedge clk) disable iff (!rstN)
    !seenCommit |-> (padOe == '0 && ctrlOut == '0));

  assert_write_quiets_pin_R5: assert property (@(posedge clk) disable iff (!rstN)
    (funcWrHit && !cfgUpdate) |=> !padOe[$past(wrAddr[CFG_ADDR_W-2:0])]);

  assert_pads_follow_status_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !cfgUpdate) |=>
      (!$stable(statusIn) || ($stable(padOe) && $stable(padOut))));

  assert_ctrl_follows_sync_R9: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && !wrEn && !cfgUpdate && $past(padIn) == $past(padIn, 2))
      |=> $stable(ctrlOut));
endmodule

bind mfp_pins mfp_pins_chk #(
  .NUM_PINS(NUM_PINS), .NUM_STATUS(NUM_STATUS),
  .NUM_CTRL(NUM_CTRL), .SEL_W(SEL_W)
) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .cfgUpdate(cfgUpdate), .statusIn(statusIn), .padIn(padIn),
  .padOut(padOut), .padOe(padOe), .ctrlOut(ctrlOut)
);

// File: tb/test_mfp_pins.sv
`timescale 1ns/1ps
module test_mfp_pins;
  localparam int NP = 7, NS = 16, NC = 8, AW = 4;

  logic          clk = 1'b0;
  logic          rstN, wrEn, cfgUpdate;
  logic [AW-1:0] wrAddr;
  logic [7:0]    wrData;
  logic [NS-1:0] statusIn;
  logic [NP-1:0] padIn, padOut, padOe;
  logic [NC-1:0] ctrlOut;
  logic [7:0]    modeSh [2];
  int            total = 0, fails = 0;

  always #2.5 clk = ~clk;

  mfp_pins i_mfp_pins (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgUpdate(cfgUpdate), .statusIn(statusIn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .ctrlOut(ctrlOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic commitCfg();
    @(negedge clk); cfgUpdate = 1'b1;
    @(negedge clk); cfgUpdate = 1'b0;
  endtask

  task automatic setPin(input int p, input logic [1:0] mode, input logic [7:0] func);
    modeSh[p/4][2*(p%4) +: 2] = mode;
    wrReg(AW'(8 + p), func);
    wrReg(AW'(p/4), modeSh[p/4]);
  endtask

  task automatic setPads(input logic [NP-1:0] v);
    @(negedge clk); padIn = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 padOe", 32'(padOe), 32'h0);
    chk("R1 ctrlOut", 32'(ctrlOut), 32'h0);
  endtask

  task automatic testPushPull();
    setPin(0, 2'b00, 8'h83);
    setPin(1, 2'b01, 8'h83);
    setPin(2, 2'b00, 8'hE4);        // select 100: beyond status width
    commitCfg();
    statusIn = 16'h0000; #1;
    chk("R2 oe", 32'(padOe[2:0]), 32'h7);
    chk("R2 out low", 32'(padOut[2:0]), 32'h2);
    statusIn = 16'hFFFF; #1;
    chk("R2 out high", 32'(padOut[1:0]), 32'h1);
    chk("R4 out-of-range select", 32'(padOut[2]), 32'h0);
  endtask

  task automatic testOpenDrain();
    setPin(4, 2'b10, 8'h85);
    setPin(5, 2'b11, 8'h85);
    commitCfg();
    statusIn = 16'h0000; #1;
    chk("R3 float when low", 32'(padOe[5:4]), 32'h0);
    statusIn = 16'h0020; #1;
    chk("R3 drive when high", 32'(padOe[5:4]), 32'h3);
    chk("R3 drive level", 32'(padOut[5:4]), 32'h1);
  endtask

  task automatic testQuiet();
    statusIn = 16'h0030;
    wrReg(4'h8, 8'h84);
    chk("R5 func write quiets pin0", 32'(padOe[0]), 32'h0);
    chk("R5 pin1 untouched", 32'(padOe[1]), 32'h1);
    commitCfg();
    chk("R6 pin0 live oe", 32'(padOe[0]), 32'h1);
    chk("R6 pin0 new select", 32'(padOut[0]), 32'h1);
    wrReg(4'h1, modeSh[1]);
    chk("R5 bank write quiets pins 4,5", 32'(padOe[5:4]), 32'h0);
    commitCfg();
    chk("R6 pins 4,5 restored", 32'(padOe[5:4]), 32'h3);
  endtask

  task automatic testCombiner();
    for (int p = 4; p < 7; p++) setPin(p, 2'b00, 8'h7F);
    setPin(0, 2'b10, 8'h02);
    setPin(1, 2'b11, 8'h02);
    setPin(2, 2'b00, 8'h02);
    setPin(3, 2'b01, 8'h02);
    commitCfg();
    for (int v = 0; v < 16; v++) begin
      logic e;
      setPads(NP'(v));
      e = (v[0] || !v[1]) && v[2] && !v[3];
      chk("R7 (p0|!p1)&p2&!p3", 32'(ctrlOut), 32'(e) << 2);
    end
  endtask

  task automatic testGroupsAndIgnored();
    setPin(2, 2'b00, 8'h7F);
    setPin(3, 2'b00, 8'h7F);
    setPin(0, 2'b00, 8'h01);        // AND group only
    setPin(1, 2'b10, 8'h04);        // OR group only
    commitCfg();
    setPads(7'b0000001);
    chk("R8 and-only true", 32'(ctrlOut), 32'h02);
    setPads(7'b0000010);
    chk("R8 or-only true", 32'(ctrlOut), 32'h10);
    setPads(7'b0000011);
    chk("R8 both, unmapped zero", 32'(ctrlOut), 32'h12);
    wrReg(4'hF, 8'h00);
    wrReg(4'h2, 8'hFF);
    @(negedge clk);
    chk("R10 stray writes ignored", 32'(ctrlOut), 32'h12);
    wrReg(4'h8, 8'h01);
    chk("R5 quiet input drops term", 32'(ctrlOut), 32'h10);
    commitCfg();
    chk("R6 input restored", 32'(ctrlOut), 32'h12);
  endtask

  task automatic testSync();
    @(negedge clk); padIn = 7'b0000010;
    @(negedge clk);
    chk("R9 not after first edge", 32'(ctrlOut), 32'h12);
    @(negedge clk);
    chk("R9 after second edge", 32'(ctrlOut), 32'h10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; cfgUpdate = 1'b0;
    wrAddr = '0; wrData = '0; statusIn = '0; padIn = '0;
    modeSh[0] = 8'h00; modeSh[1] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPushPull();
    testOpenDrain();
    testQuiet();
    testCombiner();
    testGroupsAndIgnored();
    testSync();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule